// File: doc/BRIEF.md
# Calendar Time Counter Core

This core keeps wall-clock time for a chip. A prescaler divides the core clock by `TICK_DIV` to make a one-second tick. Each tick advances a cascade of calendar counters: seconds, minutes, hours, day of month, day of week, day of year, month and year. Software reaches the core through a plain word-addressed register bus. The bus has a write strobe, a byte address, write data and combinational read data. Each counter has its own read/write register. Three packed read-only words return the whole time at once.

A control register turns counting on and can hold the prescaler cleared. An eight-bit increment mask picks which counters raise the interrupt flag when a tick advances them. To reload the time safely, software stops the clock or writes seconds as zero first, then writes the higher fields, then the real seconds value.

The prescaler is a small state machine with three states:
- `P_HALT`: the count is frozen.
- `P_CLEAR`: the count is forced to zero.
- `P_COUNT`: the count advances and a tick is produced when it reaches `TICK_DIV-1`.

The transitions are evaluated on every clock from the control bits:
- The clear bit set leads to `P_CLEAR`, from any state.
- The clear bit low with enable high leads to `P_COUNT`.
- Both bits low lead to `P_HALT`.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time is 00:00:00 on day-of-month 1, month 1, year 0, day-of-week 0, day-of-year 1. The control bits, the mask and the increment flag are all 0.
- R2: Counting happens only while control bit 0 (enable) is 1 and bit 1 (prescaler clear) is 0. After enable is written with the prescaler cleared, the first tick lands on the (`TICK_DIV`+1)-th rising edge after the write edge. Later ticks follow every `TICK_DIV` edges.
- R3: While control bit 1 is set, the prescaler is held at zero and no counter advances, even with enable set.
- R4: Seconds and minutes wrap 59 to 0 and hours wrap 23 to 0. Each wrap carries into the next field.
- R5: An hour wrap advances day-of-month, day-of-week and day-of-year together. Day-of-week wraps 6 to 0.
- R6: Day-of-month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11; 28 for month 2, or 29 when year mod 4 is 0; 31 otherwise. That wrap advances the month, and month 12 wraps to 1 and increments the year.
- R7: Day-of-year wraps to 1 after 365, or after 366 when year mod 4 is 0.
- R8: The snapshot words are read-only.
  - Word 0x14 holds seconds in [5:0], minutes in [13:8], hours in [20:16] and day-of-week in [26:24].
  - Word 0x18 holds day-of-month in [4:0], month in [11:8] and year in [27:16].
  - Word 0x1C holds day-of-year in [11:0].
  - All other bits read 0, and every field comes from the same clock cycle.
- R9: Addresses 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34, 0x38 and 0x3C hold seconds, minutes, hours, day-of-month, day-of-week, day-of-year, month and year. Each reads its field zero-extended. A write sets the field from the write data at that edge.
- R10: The increment mask at 0x0C orders its bits 0 to 7 the same way as the counters at 0x20–0x3C.
  - A tick that advances a field whose mask bit is 1 sets the flag, read at address 0x00 bit 0 and driven on `inc_irq`.
  - Writing 1 to 0x00 bit 0 clears the flag.
  - Bus writes to counters and advances of unmasked fields leave the flag unchanged.
- R11: The control register at 0x08 reads back enable in bit 0, prescaler clear in bit 1 and a stored calibration-off bit in bit 4. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, also the prescaler reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| inc_irq | output | 1 | Increment flag, high until cleared by software |

## Verification
A wrong prescaler state shows first as a seconds register that steps one edge early or late, or that keeps stepping under clear. The bench therefore counts edges exactly from the enabling write. A wrong wrap limit or a missing carry in the cascade appears at the next tick as a wrong field in the individual registers and the snapshot words. The bench loads each boundary time just before the rollover, so a single tick exposes the error. A mask or flag fault shows on `inc_irq` at the same edge as the counter change, or as a flag that a counter write or an unmasked advance wrongly set.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [1:0] {
        P_HALT,
        P_CLEAR,
        P_COUNT
    } psc_state_e;

    typedef struct packed {
        logic [11:0] year;
        logic [3:0]  mon;
        logic [11:0] doy;
        logic [2:0]  dow;
        logic [4:0]  dom;
        logic [4:0]  hour;
        logic [5:0]  min;
        logic [5:0]  sec;
    } cal_time_t;

    // Field index order shared by counter addresses and the increment mask
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOM  = 3;
    localparam int F_DOW  = 4;
    localparam int F_DOY  = 5;
    localparam int F_MON  = 6;
    localparam int F_YEAR = 7;
    localparam int NFIELD = 8;

    localparam cal_time_t TIME_AT_RESET = '{
        year: 12'd0, mon: 4'd1, doy: 12'd1, dow: 3'd0,
        dom: 5'd1, hour: 5'd0, min: 6'd0, sec: 6'd0
    };

    function automatic logic is_leap(input logic [11:0] yr);
        return (yr[1:0] == 2'b00);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mo, input logic [11:0] yr);
        logic [4:0] n;
        case (mo)
            4'd2:                      n = is_leap(yr) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
            default:                   n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_cal_pkg::*;
#(
    parameter int unsigned TICK_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic hold_clr,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    psc_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        if (hold_clr)    state_d = P_CLEAR;
        else if (run_en) state_d = P_COUNT;
        else             state_d = P_HALT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                P_CLEAR: cnt_q <= '0;
                P_COUNT: cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                P_HALT:  cnt_q <= cnt_q;
                default: cnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        tick = (state_q == P_COUNT) && (cnt_q == LAST);
    end

    // R3: the clear state leaves a zero count behind
    a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == P_CLEAR) |=> (cnt_q == '0));

    // R2: no tick while halted or clearing
    a_r2_tick_only_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != P_COUNT) |-> !tick);

    // R2: ticks are never back to back when the divider exceeds one
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (TICK_DIV > 1)) |=> !tick);

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NFIELD-1:0] wr_en,
    input  logic [11:0]       wr_val,
    output cal_time_t         now,
    output logic [NFIELD-1:0] adv
);
    cal_time_t nxt;
    logic sec_top, min_top, hour_top, dom_top, dow_top, doy_top, mon_top;
    logic day_step;

    always_comb begin
        sec_top  = (now.sec  >= 6'd59);
        min_top  = (now.min  >= 6'd59);
        hour_top = (now.hour >= 5'd23);
        dom_top  = (now.dom  >= month_len(now.mon, now.year));
        dow_top  = (now.dow  >= 3'd6);
        doy_top  = (now.doy  >= (is_leap(now.year) ? 12'd366 : 12'd365));
        mon_top  = (now.mon  >= 4'd12);

        adv           = '0;
        adv[F_SEC]    = tick;
        adv[F_MIN]    = tick & sec_top;
        adv[F_HOUR]   = adv[F_MIN] & min_top;
        day_step      = adv[F_HOUR] & hour_top;
        adv[F_DOM]    = day_step;
        adv[F_DOW]    = day_step;
        adv[F_DOY]    = day_step;
        adv[F_MON]    = day_step & dom_top;
        adv[F_YEAR]   = adv[F_MON] & mon_top;

        nxt = now;
        if (adv[F_SEC])  nxt.sec  = sec_top  ? 6'd0  : now.sec  + 6'd1;
        if (adv[F_MIN])  nxt.min  = min_top  ? 6'd0  : now.min  + 6'd1;
        if (adv[F_HOUR]) nxt.hour = hour_top ? 5'd0  : now.hour + 5'd1;
        if (adv[F_DOM])  nxt.dom  = dom_top  ? 5'd1  : now.dom  + 5'd1;
        if (adv[F_DOW])  nxt.dow  = dow_top  ? 3'd0  : now.dow  + 3'd1;
        if (adv[F_DOY])  nxt.doy  = doy_top  ? 12'd1 : now.doy  + 12'd1;
        if (adv[F_MON])  nxt.mon  = mon_top  ? 4'd1  : now.mon  + 4'd1;
        if (adv[F_YEAR]) nxt.year = now.year + 12'd1;

        // A bus write overrides the tick result for its own field
        if (wr_en[F_SEC])  nxt.sec  = wr_val[5:0];
        if (wr_en[F_MIN])  nxt.min  = wr_val[5:0];
        if (wr_en[F_HOUR]) nxt.hour = wr_val[4:0];
        if (wr_en[F_DOM])  nxt.dom  = wr_val[4:0];
        if (wr_en[F_DOW])  nxt.dow  = wr_val[2:0];
        if (wr_en[F_DOY])  nxt.doy  = wr_val[11:0];
        if (wr_en[F_MON])  nxt.mon  = wr_val[3:0];
        if (wr_en[F_YEAR]) nxt.year = wr_val[11:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now <= TIME_AT_RESET;
        else        now <= nxt;
    end

    // R2: without a tick or a write the time stands still
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && (wr_en == '0)) |=> (now == $past(now)));

    // R4: seconds roll over to zero and minutes step
    a_r4_sec_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && now.sec == 6'd59 && now.min < 6'd59 && wr_en == '0)
        |=> (now.sec == 6'd0 && now.min == $past(now.min) + 6'd1));

    // R5: day-of-week wraps from 6 to 0 on a day step
    a_r5_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && now.sec == 6'd59 && now.min == 6'd59 && now.hour == 5'd23
         && now.dow == 3'd6 && wr_en == '0) |=> (now.dow == 3'd0));

    // R6: last second of the year carries into the year counter
    a_r6_year_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && now.sec == 6'd59 && now.min == 6'd59 && now.hour == 5'd23
         && now.dom == 5'd31 && now.mon == 4'd12 && wr_en == '0)
        |=> (now.year == $past(now.year) + 12'd1 && now.mon == 4'd1 && now.dom == 5'd1));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int unsigned TICK_DIV = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        inc_irq
);
    localparam logic [5:0] W_FLAG  = 6'h00;
    localparam logic [5:0] W_CTRL  = 6'h02;
    localparam logic [5:0] W_MASK  = 6'h03;
    localparam logic [5:0] W_SNAP0 = 6'h05;
    localparam logic [5:0] W_SNAP1 = 6'h06;
    localparam logic [5:0] W_SNAP2 = 6'h07;

    logic [5:0] word;
    logic       aligned;
    logic       ctl_en, ctl_pclr, ctl_caloff;
    logic [NFIELD-1:0] mask_q, wr_en, adv;
    logic       flag_q, tick;
    cal_time_t  now;
    logic       unused_bits;

    assign word        = bus_addr[7:2];
    assign aligned     = (bus_addr[1:0] == 2'b00);
    assign unused_bits = ^bus_wdata[31:12];

    always_comb begin
        wr_en = '0;
        if (bus_we && aligned && bus_addr[7:5] == 3'b001)
            wr_en = NFIELD'(1) << bus_addr[4:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en     <= 1'b0;
            ctl_pclr   <= 1'b0;
            ctl_caloff <= 1'b0;
            mask_q     <= '0;
        end else if (bus_we && aligned) begin
            if (word == W_CTRL) begin
                ctl_en     <= bus_wdata[0];
                ctl_pclr   <= bus_wdata[1];
                ctl_caloff <= bus_wdata[4];
            end
            if (word == W_MASK) mask_q <= bus_wdata[NFIELD-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (|(adv & mask_q))
            flag_q <= 1'b1;
        else if (bus_we && aligned && word == W_FLAG && bus_wdata[0])
            flag_q <= 1'b0;
    end

    assign inc_irq = flag_q;

    rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (ctl_en),
        .hold_clr (ctl_pclr),
        .tick     (tick)
    );

    rtc_time_chain u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wr_en  (wr_en),
        .wr_val (bus_wdata[11:0]),
        .now    (now),
        .adv    (adv)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (word)
                W_FLAG:  bus_rdata = {31'd0, flag_q};
                W_CTRL:  bus_rdata = {27'd0, ctl_caloff, 2'b00, ctl_pclr, ctl_en};
                W_MASK:  bus_rdata = {24'd0, mask_q};
                W_SNAP0: bus_rdata = {5'd0, now.dow, 3'd0, now.hour, 2'd0, now.min, 2'd0, now.sec};
                W_SNAP1: bus_rdata = {4'd0, now.year, 4'd0, now.mon, 3'd0, now.dom};
                W_SNAP2: bus_rdata = {20'd0, now.doy};
                6'h08:   bus_rdata = {26'd0, now.sec};
                6'h09:   bus_rdata = {26'd0, now.min};
                6'h0A:   bus_rdata = {27'd0, now.hour};
                6'h0B:   bus_rdata = {27'd0, now.dom};
                6'h0C:   bus_rdata = {29'd0, now.dow};
                6'h0D:   bus_rdata = {20'd0, now.doy};
                6'h0E:   bus_rdata = {28'd0, now.mon};
                6'h0F:   bus_rdata = {20'd0, now.year};
                default: bus_rdata = '0;
            endcase
        end
    end

    // R10: a masked advance always leaves the flag set
    a_r10_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|(adv & mask_q)) |=> inc_irq);

    // R10: the flag never rises without a masked advance
    a_r10_flag_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_irq && ((adv & mask_q) == '0)) |=> !inc_irq);

    // R3: clear bit keeps the time frozen apart from bus writes
    a_r3_frozen_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pclr && wr_en == '0) |=> $stable(now));

endmodule

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        inc_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    rtc_calendar_core #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inc_irq(inc_irq)
    );

    localparam logic [7:0] A_FLAG = 8'h00, A_CTRL = 8'h08, A_MASK = 8'h0C;
    localparam logic [7:0] A_S0 = 8'h14, A_S1 = 8'h18, A_S2 = 8'h1C;
    localparam logic [7:0] A_SEC = 8'h20, A_MIN = 8'h24, A_HR = 8'h28, A_DOM = 8'h2C;
    localparam logic [7:0] A_DOW = 8'h30, A_DOY = 8'h34, A_MON = 8'h38, A_YR = 8'h3C;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic load_time(input int yr, input int mo, input int dm, input int dw,
                             input int dy, input int hr, input int mi, input int se);
        bus_write(A_SEC, 0);
        bus_write(A_YR, yr);  bus_write(A_MON, mo); bus_write(A_DOM, dm);
        bus_write(A_DOW, dw); bus_write(A_DOY, dy); bus_write(A_HR, hr);
        bus_write(A_MIN, mi); bus_write(A_SEC, se);
    endtask

    // Exactly one tick: clear the prescaler, enable, wait DIV+1 edges, stop
    task automatic one_tick();
        bus_write(A_CTRL, 32'h2);
        bus_write(A_CTRL, 32'h1);
        repeat (DIV + 1) @(posedge clk);
        bus_write(A_CTRL, 32'h0);
    endtask

    task automatic t_reset();
        expect_reg("R1 sec", A_SEC, 0);  expect_reg("R1 min", A_MIN, 0);
        expect_reg("R1 hour", A_HR, 0);  expect_reg("R1 dom", A_DOM, 1);
        expect_reg("R1 dow", A_DOW, 0);  expect_reg("R1 doy", A_DOY, 1);
        expect_reg("R1 mon", A_MON, 1);  expect_reg("R1 year", A_YR, 0);
        expect_reg("R1 ctrl", A_CTRL, 0); expect_reg("R1 mask", A_MASK, 0);
        expect_reg("R1 flag", A_FLAG, 0); check("R1 irq", {31'd0, inc_irq}, 0);
    endtask

    task automatic t_counting();
        load_time(2023, 5, 10, 2, 130, 8, 0, 20);
        bus_write(A_CTRL, 32'h2);
        bus_write(A_CTRL, 32'h1);
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        expect_reg("R2 before first tick", A_SEC, 20);
        @(posedge clk); @(negedge clk);
        expect_reg("R2 first tick edge", A_SEC, 21);
        repeat (4 * DIV) @(posedge clk);
        @(negedge clk);
        expect_reg("R2 five ticks", A_SEC, 25);
        bus_write(A_CTRL, 32'h0);
        repeat (3 * DIV) @(posedge clk);
        @(negedge clk);
        expect_reg("R2 halted no advance", A_SEC, 25);
    endtask

    task automatic t_prescaler_hold();
        bus_write(A_CTRL, 32'h3);
        repeat (4 * DIV) @(posedge clk);
        @(negedge clk);
        expect_reg("R3 held with enable", A_SEC, 25);
        bus_write(A_CTRL, 32'h0);
    endtask

    task automatic t_tod_wrap();
        load_time(2023, 5, 10, 2, 130, 13, 45, 59);
        one_tick();
        expect_reg("R4 sec wrap", A_SEC, 0);
        expect_reg("R4 min carry", A_MIN, 46);
        load_time(2023, 5, 10, 2, 130, 13, 59, 59);
        one_tick();
        expect_reg("R4 hour carry", A_HR, 14);
        expect_reg("R4 min wrap", A_MIN, 0);
        expect_reg("R4 dom untouched", A_DOM, 10);
    endtask

    task automatic t_day_carry();
        load_time(2023, 5, 10, 6, 130, 23, 59, 59);
        one_tick();
        expect_reg("R5 hour wrap", A_HR, 0);
        expect_reg("R5 dom step", A_DOM, 11);
        expect_reg("R5 dow wrap", A_DOW, 0);
        expect_reg("R5 doy step", A_DOY, 131);
        expect_reg("R5 mon same", A_MON, 5);
    endtask

    task automatic t_month_len();
        load_time(2023, 2, 28, 1, 59, 23, 59, 59);
        one_tick();
        expect_reg("R6 feb common dom", A_DOM, 1);
        expect_reg("R6 feb common mon", A_MON, 3);
        load_time(2024, 2, 28, 3, 59, 23, 59, 59);
        one_tick();
        expect_reg("R6 feb leap dom", A_DOM, 29);
        expect_reg("R6 feb leap mon", A_MON, 2);
        load_time(2024, 2, 29, 4, 60, 23, 59, 59);
        one_tick();
        expect_reg("R6 feb29 to mar", A_MON, 3);
        load_time(2023, 4, 30, 0, 120, 23, 59, 59);
        one_tick();
        expect_reg("R6 30-day month", A_MON, 5);
        expect_reg("R6 30-day dom", A_DOM, 1);
        load_time(2023, 12, 31, 0, 365, 23, 59, 59);
        one_tick();
        expect_reg("R6 year step", A_YR, 2024);
        expect_reg("R6 mon wrap", A_MON, 1);
        expect_reg("R7 doy common wrap", A_DOY, 1);
    endtask

    task automatic t_doy_wrap();
        load_time(2024, 12, 30, 1, 365, 23, 59, 59);
        one_tick();
        expect_reg("R7 leap doy 366", A_DOY, 366);
        one_tick();
        expect_reg("R7 still 366 mid-day", A_DOY, 366);
        load_time(2024, 12, 31, 2, 366, 23, 59, 59);
        one_tick();
        expect_reg("R7 leap doy wrap", A_DOY, 1);
        expect_reg("R7 year after leap", A_YR, 2025);
    endtask

    task automatic t_snapshot();
        load_time(2031, 11, 27, 4, 331, 17, 42, 9);
        expect_reg("R8 word0", A_S0, (32'd4 << 24) | (32'd17 << 16) | (32'd42 << 8) | 32'd9);
        expect_reg("R8 word1", A_S1, (32'd2031 << 16) | (32'd11 << 8) | 32'd27);
        expect_reg("R8 word2", A_S2, 32'd331);
        bus_write(A_S0, 32'hFFFF_FFFF);
        expect_reg("R8 read-only", A_S0, (32'd4 << 24) | (32'd17 << 16) | (32'd42 << 8) | 32'd9);
    endtask

    task automatic t_counter_regs();
        expect_reg("R9 sec", A_SEC, 9);   expect_reg("R9 min", A_MIN, 42);
        expect_reg("R9 hour", A_HR, 17);  expect_reg("R9 dom", A_DOM, 27);
        expect_reg("R9 dow", A_DOW, 4);   expect_reg("R9 doy", A_DOY, 331);
        expect_reg("R9 mon", A_MON, 11);  expect_reg("R9 year", A_YR, 2031);
        bus_write(A_YR, 32'hABCD_F7FF);
        expect_reg("R9 year field width", A_YR, 32'h7FF);
    endtask

    task automatic t_irq();
        load_time(2023, 5, 10, 2, 130, 10, 5, 5);
        bus_write(A_MASK, 32'h01);
        bus_write(A_FLAG, 32'h1);
        bus_write(A_SEC, 7);
        expect_reg("R10 write no flag", A_FLAG, 0);
        one_tick();
        check("R10 sec mask irq", {31'd0, inc_irq}, 1);
        bus_write(A_FLAG, 32'h1);
        check("R10 clear", {31'd0, inc_irq}, 0);
        bus_write(A_MASK, 32'h02);
        one_tick();
        expect_reg("R10 unmasked sec", A_FLAG, 0);
        bus_write(A_SEC, 59);
        one_tick();
        check("R10 min mask irq", {31'd0, inc_irq}, 1);
        bus_write(A_FLAG, 32'h1);
        bus_write(A_MASK, 32'h0);
    endtask

    task automatic t_ctrl();
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        expect_reg("R11 ctrl readback", A_CTRL, 32'h13);
        bus_write(A_CTRL, 32'h10);
        expect_reg("R11 caloff only", A_CTRL, 32'h10);
        bus_write(A_CTRL, 32'h0);
    endtask

    initial begin
        #(10 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counting();
        t_prescaler_hold();
        t_tod_wrap();
        t_day_carry();
        t_month_len();
        t_doy_wrap();
        t_snapshot();
        t_counter_regs();
        t_irq();
        t_ctrl();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule